// File: doc/BRIEF.md
# Synchronous Burst SRAM with Pipelined Deselect

This block is a synthesizable behavioral model of a small synchronous burst SRAM with byte-granular writes. Every address, data and control input is sampled on the rising clock edge. Three chip selects, two address strobes (a host-side one that can only start reads and a controller-side one that can start reads or writes), a burst step input and the write controls are decoded into begin, continue, suspend or deselect cycles. A two-bit burst counter walks the low address bits in either linear or interleaved order.

Read data leaves the block either straight from the array (flow-through) or through an output register (pipelined). A deselect travels through the same output pipeline as a read, so in pipelined mode the drivers stay on for one full cycle after a deselect and turn off only after the second rising edge. The shared data bus is split into `din`, `dout` and an output-enable `dq_oe`. An asynchronous active-low output enable gates the drivers, and a sampled sleep request blocks array writes, turns the drivers off and keeps memory contents.

Top module: `burst_sram`

## Requirements
- R1: A cycle with an active strobe starts an access only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0; otherwise it is a deselect that neither reads nor writes and ends any running burst.
- R2: On cycles with no active strobe, `cs1` and `cs2_n` are ignored: a running burst continues with them deasserted.
- R3: `cs0_n`=1 masks `host_stb_n`: a host strobe under `cs0_n`=1 is treated as a cycle with no strobe, so a running burst continues.
- R4: `wr_all_n`=0 writes every byte; otherwise `wr_byte_n`=0 writes byte b (bits b*BYTE_W upward) for each `byte_sel_n[b]`=0; in every other case, including `wr_byte_n`=0 with all `byte_sel_n` high, the cycle is a read.
- R5: A cycle started by `host_stb_n`=0 (with `cs0_n`=0) is always a read; a write begins only with `ctl_stb_n`=0, `host_stb_n`=1 and the write condition of R4.
- R6: Burst beat k (k = 0..3, wrapping after four) uses address bits [1:0] equal to base+k mod 4 when `lin_order_n`=0 and base XOR k when `lin_order_n`=1; upper bits stay those of the start address; a continue cycle steps k when `burst_step_n`=0 and holds it when 1; each write beat writes the current burst address with data captured on that edge.
- R7: With `pipe_mode`=0 read data and `dq_oe` appear after the edge that samples the read; with `pipe_mode`=1 they appear after the following edge; `dq_oe` is low out of reset.
- R8: In pipelined mode, after a read followed by a deselect, the drivers keep driving the read data for one cycle and turn off after the second edge following the deselect.
- R9: In the cycle following a write edge, `dq_oe` is low even if an earlier pipelined read is still in the output stage.
- R10: `out_en_n`=1 drives `dq_oe` low at once, independent of the clock; `out_en_n`=0 raises `dq_oe` only while the synchronous logic delivers read data.
- R11: An edge that samples `sleep_req`=1 performs no array write, ends the burst, and holds `dq_oe` low until the next edge; memory contents are kept.
- R12: Commands at the first two edges that sample `sleep_req`=0 after an edge sampling it high (and after reset) are ignored; the third edge accepts commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded when a burst starts |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data, valid while dq_oe is high |
| dq_oe | output | 1 | Data driver enable |
| cs0_n | input | 1 | Chip select, active low, also masks the host strobe |
| cs1 | input | 1 | Chip select, active high, used on strobe cycles |
| cs2_n | input | 1 | Chip select, active low, used on strobe cycles |
| host_stb_n | input | 1 | Host-side address strobe, read-only start |
| ctl_stb_n | input | 1 | Controller-side address strobe |
| burst_step_n | input | 1 | Burst counter step on continue cycles, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| byte_sel_n | input | BYTES | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, sampled on the clock |
| pipe_mode | input | 1 | 1 = pipelined output register, 0 = flow-through |
| lin_order_n | input | 1 | 0 = linear burst order, 1 = interleaved |

## Verification
The bench builds the block with its defaults: 256 words of two 9-bit bytes, an 8-bit address and a 2-bit burst counter. That depth is small enough to fill the whole array first and compare every read against a reference array, while the two-byte width reaches every byte-mask pattern and the two low address bits give both burst orders from all four start offsets, including wrap-around. Random traffic switches output mode and burst order during the run, so deselects, writes, sleep and output-enable pulses land in both latency modes.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

endpackage

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] addr_now
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_use, low_sel;

  always_comb begin
    cnt_use  = step ? cnt_q + ONE : cnt_q;
    low_sel  = linear ? (base_q[CNT_W-1:0] + cnt_use) : (base_q[CNT_W-1:0] ^ cnt_use);
    addr_now = load ? load_addr : {base_q[ADDR_W-1:CNT_W], low_sel};
    base_d   = base_q;
    cnt_d    = cnt_q;
    if (load) begin
      base_d = load_addr;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d  = cnt_use;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load || step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int BYTES    = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             host_stb_n,
  input  logic             ctl_stb_n,
  input  logic             burst_step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [BYTES-1:0] byte_sel_n,
  input  logic             sleep_req,
  output cmd_e             cmd,
  output logic             ctr_load,
  output logic             ctr_step,
  output logic [BYTES-1:0] byte_we
);

  localparam int WAKE_W = $clog2(WAKE_CYC + 1);
  localparam logic [WAKE_W-1:0] WAKE_INIT = WAKE_W'(WAKE_CYC);
  localparam logic [WAKE_W-1:0] WAKE_ONE  = {{(WAKE_W-1){1'b0}}, 1'b1};

  logic [WAKE_W-1:0] wake_q, wake_d;
  logic              burst_q, burst_d;
  logic              blocked, host_go, ctl_go, selected, wr_cond;
  logic [BYTES-1:0]  mask;

  always_comb begin
    blocked  = sleep_req || (wake_q != '0);
    host_go  = !host_stb_n && !cs0_n;
    ctl_go   = !host_go && !ctl_stb_n;
    selected = !cs0_n && cs1 && !cs2_n;
    mask     = !wr_all_n ? {BYTES{1'b1}} : (!wr_byte_n ? ~byte_sel_n : '0);
    wr_cond  = |mask;

    cmd      = CMD_IDLE;
    ctr_load = 1'b0;
    ctr_step = 1'b0;
    burst_d  = burst_q;

    if (blocked) begin
      burst_d = 1'b0;
    end else if (host_go || ctl_go) begin
      if (selected) begin
        ctr_load = 1'b1;
        burst_d  = 1'b1;
        cmd      = (ctl_go && wr_cond) ? CMD_WRITE : CMD_READ;
      end else begin
        burst_d  = 1'b0;
        cmd      = CMD_DESEL;
      end
    end else if (burst_q) begin
      ctr_step = !burst_step_n;
      cmd      = wr_cond ? CMD_WRITE : CMD_READ;
    end

    byte_we = (cmd == CMD_WRITE) ? mask : '0;

    wake_d = wake_q;
    if (sleep_req) begin
      wake_d = WAKE_INIT;
    end else if (wake_q != '0) begin
      wake_d = wake_q - WAKE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= WAKE_INIT;
      burst_q <= 1'b0;
    end else begin
      wake_q  <= wake_d;
      burst_q <= burst_d;
    end
  end

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
  parameter int ADDR_W = 8,
  parameter int DW     = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] addr_now,
  input  logic [DW-1:0]     rdata,
  input  logic              sleep_req,
  input  logic              pipe_mode,
  input  logic              out_en_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     dout,
  output logic              dq_oe
);

  logic          s1_rd_q, s1_wr_q, s2_rd_q, sleep_q;
  logic [DW-1:0] s2_data_q;
  logic          sync_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd_q <= 1'b0;
      s1_wr_q <= 1'b0;
      s2_rd_q <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      s1_rd_q <= rd_go;
      s1_wr_q <= wr_go;
      s2_rd_q <= s1_rd_q;
      sleep_q <= sleep_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
    end else if (rd_go) begin
      rd_addr <= addr_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_data_q <= '0;
    end else if (s1_rd_q) begin
      s2_data_q <= rdata;
    end
  end

  always_comb begin
    sync_on = pipe_mode ? s2_rd_q : s1_rd_q;
    dout    = pipe_mode ? s2_data_q : rdata;
    dq_oe   = sync_on && !s1_wr_q && !sleep_q && !out_en_n;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dq_oe,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    host_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    burst_step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [BYTES-1:0]        byte_sel_n,
  input  logic                    out_en_n,
  input  logic                    sleep_req,
  input  logic                    pipe_mode,
  input  logic                    lin_order_n
);

  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cmd_e              cmd;
  logic              ctr_load, ctr_step;
  logic [BYTES-1:0]  byte_we;
  logic [ADDR_W-1:0] addr_now, rd_addr;
  logic [DW-1:0]     rdata;
  logic [DW-1:0]     mem [DEPTH];

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sram_cmd_decode #(.BYTES(BYTES)) u_decode (
    .clk(clk), .rst_n(rst_int_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .host_stb_n(host_stb_n), .ctl_stb_n(ctl_stb_n), .burst_step_n(burst_step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .sleep_req(sleep_req),
    .cmd(cmd), .ctr_load(ctr_load), .ctr_step(ctr_step), .byte_we(byte_we)
  );

  burst_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(2)) u_ctr (
    .clk(clk), .rst_n(rst_int_n),
    .load(ctr_load), .step(ctr_step), .linear(!lin_order_n),
    .load_addr(addr), .addr_now(addr_now)
  );

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (byte_we[b]) mem[addr_now][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[rd_addr];

  sram_out_pipe #(.ADDR_W(ADDR_W), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_int_n),
    .rd_go(cmd == CMD_READ), .wr_go(cmd == CMD_WRITE),
    .addr_now(addr_now), .rdata(rdata), .sleep_req(sleep_req),
    .pipe_mode(pipe_mode), .out_en_n(out_en_n),
    .rd_addr(rd_addr), .dout(dout), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/sram_checker.sv
module sram_checker
  import sram_pkg::*;
#(
  parameter int BYTES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_en_n,
  input logic             sleep_req,
  input logic             pipe_mode,
  input logic             dq_oe,
  input cmd_e             cmd,
  input logic [BYTES-1:0] byte_we
);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  assert_flow_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && dq_oe) |-> ($past(cmd) == CMD_READ));

  assert_pipe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dq_oe) |-> ($past(cmd, 2) == CMD_READ));

  assert_wr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == CMD_WRITE) |-> !dq_oe);

  assert_sleep_nowr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (byte_we == '0));

  assert_sleep_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_req) |-> !dq_oe);

  assert_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_req) && !sleep_req) |-> (cmd == CMD_IDLE));

endmodule

bind burst_sram sram_checker #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .sleep_req(sleep_req),
  .pipe_mode(pipe_mode), .dq_oe(dq_oe), .cmd(cmd), .byte_we(byte_we)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

  localparam int AW = 8, NB = 2, BW = 9, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dq_oe, cs0_n, cs1, cs2_n, host_stb_n, ctl_stb_n, burst_step_n;
  logic wr_all_n, wr_byte_n, out_en_n, sleep_req, pipe_mode, lin_order_n;
  logic [NB-1:0] byte_sel_n;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .host_stb_n(host_stb_n),
    .ctl_stb_n(ctl_stb_n), .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n), .out_en_n(out_en_n),
    .sleep_req(sleep_req), .pipe_mode(pipe_mode), .lin_order_n(lin_order_n)
  );

  int    checks = 0, errors = 0;
  string tag = "R7";
  bit    model_on = 1'b0;

  // reference state, computed from the requirements
  logic [DW-1:0] mm [DEPTH];
  bit            m_act, m_v1, m_w1, m_v2, m_sq;
  logic [AW-1:0] m_base, m_a1;
  int            m_k, m_wake;
  logic [DW-1:0] m_q2;

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int k, bit lin);
    logic [1:0] lo;
    lo = lin ? 2'(int'(b[1:0]) + k) : 2'(int'(b[1:0]) ^ k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic m_step();
    bit blocked, hs, cs, sel, wr;
    int kind;
    logic [AW-1:0] a;
    blocked = sleep_req || (m_wake != 0);
    if (sleep_req) m_wake = 2; else if (m_wake != 0) m_wake--;
    hs  = !host_stb_n && !cs0_n;
    cs  = !hs && !ctl_stb_n;
    sel = !cs0_n && cs1 && !cs2_n;
    wr  = !wr_all_n || (!wr_byte_n && (byte_sel_n != '1));
    kind = 0;
    a = m_a1;
    if (blocked) m_act = 0;
    else if (hs || cs) begin
      if (sel) begin
        m_act = 1; m_base = addr; m_k = 0; a = addr;
        kind = (cs && wr) ? 2 : 1;
      end else m_act = 0;
    end else if (m_act) begin
      if (!burst_step_n) m_k = (m_k + 1) % 4;
      a = beat_addr(m_base, m_k, !lin_order_n);
      kind = wr ? 2 : 1;
    end
    if (m_v1) m_q2 = mm[m_a1];
    m_v2 = m_v1;
    m_v1 = (kind == 1);
    m_w1 = (kind == 2);
    if (kind == 1) m_a1 = a;
    m_sq = sleep_req;
    if (kind == 2)
      for (int b = 0; b < NB; b++)
        if (!wr_all_n || !byte_sel_n[b]) mm[a][b*BW +: BW] = din[b*BW +: BW];
  endtask

  always @(posedge clk) if (model_on) m_step();

  task automatic chk();
    bit e_en;
    logic [DW-1:0] e_d;
    e_en = (pipe_mode ? m_v2 : m_v1) && !m_w1 && !m_sq && !out_en_n;
    checks++;
    if (dq_oe !== e_en) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b expected %0b at %0t", tag, dq_oe, e_en, $time);
    end
    if (e_en) begin
      e_d = pipe_mode ? m_q2 : mm[m_a1];
      checks++;
      if (dout !== e_d) begin
        errors++;
        $display("FAIL %s: dout=%h expected %h at %0t", tag, dout, e_d, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk();
  endtask

  task automatic quiet();
    host_stb_n = 1; ctl_stb_n = 1; burst_step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; byte_sel_n = '1;
    cs0_n = 0; cs1 = 1; cs2_n = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, bit host);
    quiet(); addr = a;
    if (host) host_stb_n = 0; else ctl_stb_n = 0;
    tick(); quiet();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit g_n, bit bw_n, logic [NB-1:0] be);
    quiet(); addr = a; din = d; ctl_stb_n = 0;
    wr_all_n = g_n; wr_byte_n = bw_n; byte_sel_n = be;
    tick(); quiet();
  endtask

  task automatic cont(bit step_n, int n);
    for (int i = 0; i < n; i++) begin
      host_stb_n = 1; ctl_stb_n = 1; burst_step_n = step_n;
      tick();
    end
    burst_step_n = 1;
  endtask

  task automatic idle(int n);
    quiet();
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_act = 0; m_v1 = 0; m_w1 = 0; m_v2 = 0; m_sq = 0; m_k = 0; m_wake = 0;
    m_base = '0; m_a1 = '0; m_q2 = '0;
    rst_n = 0; addr = '0; din = '0; out_en_n = 0; sleep_req = 0;
    pipe_mode = 1; lin_order_n = 1;
    quiet();
    repeat (3) @(negedge clk);
    tag = "R7"; chk();                 // reset state: drivers off
    rst_n = 1;
    model_on = 1;
    idle(6);

    tag = "R4";                        // fill the array with whole-word writes
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), DW'($urandom), 0, 1, '1);
    idle(2);

    tag = "R7";
    pipe_mode = 0; rd(8'h05, 0); idle(2);
    pipe_mode = 1; rd(8'h06, 0); idle(3);
    pipe_mode = 0; rd(8'h07, 1); cont(0, 3); idle(2);
    pipe_mode = 1;

    tag = "R6";
    lin_order_n = 0; rd(8'h12, 0); cont(0, 5); idle(2);
    lin_order_n = 1; rd(8'h13, 0); cont(0, 2); cont(1, 2); cont(0, 3); idle(2);
    wr(8'h21, DW'($urandom), 0, 1, '1);
    wr_all_n = 0; din = DW'($urandom); cont(0, 1); din = DW'($urandom); cont(0, 1); quiet();
    rd(8'h21, 0); cont(0, 4); idle(2);

    tag = "R2";
    rd(8'h24, 0); cs1 = 0; cs2_n = 1; cont(0, 3); quiet(); idle(2);

    tag = "R3";
    rd(8'h30, 0); cs0_n = 1; host_stb_n = 0; addr = 8'h80; burst_step_n = 0;
    tick(); quiet(); cont(0, 1); idle(2);

    tag = "R1";
    cs1 = 0; addr = 8'h40; ctl_stb_n = 0; tick(); quiet(); idle(2);
    cs2_n = 1; addr = 8'h41; host_stb_n = 0; tick(); quiet(); idle(2);
    cs0_n = 1; addr = 8'h42; ctl_stb_n = 0; wr_all_n = 0; din = '1; tick(); quiet();
    rd(8'h42, 0); idle(2);
    rd(8'h43, 0); cont(0, 1); cs1 = 0; ctl_stb_n = 0; tick(); quiet(); cont(0, 2); idle(2);

    tag = "R4";
    wr(8'h50, DW'($urandom), 1, 0, 2'b10); rd(8'h50, 0); idle(2);
    wr(8'h51, DW'($urandom), 1, 0, 2'b01); rd(8'h51, 0); idle(2);
    wr(8'h52, DW'($urandom), 1, 0, 2'b11); idle(2); rd(8'h52, 0); idle(2);
    wr(8'h53, DW'($urandom), 0, 1, 2'b11); rd(8'h53, 0); idle(2);

    tag = "R5";
    quiet(); addr = 8'h55; din = '0; host_stb_n = 0; wr_all_n = 0; tick(); quiet();
    idle(2); rd(8'h55, 0); idle(2);
    quiet(); addr = 8'h56; din = '0; host_stb_n = 0; ctl_stb_n = 0; wr_all_n = 0; tick(); quiet();
    idle(2); rd(8'h56, 0); idle(2);

    tag = "R8";
    rd(8'h60, 0); cs1 = 0; ctl_stb_n = 0; tick(); quiet(); idle(3);
    pipe_mode = 0; rd(8'h61, 0); cs2_n = 1; ctl_stb_n = 0; tick(); quiet(); idle(2);
    pipe_mode = 1;

    tag = "R9";
    rd(8'h62, 0); wr(8'h63, DW'($urandom), 0, 1, '1); idle(2); rd(8'h63, 0); idle(2);

    tag = "R10";
    pipe_mode = 0; rd(8'h64, 0);
    out_en_n = 1; #1; checks++;
    if (dq_oe !== 1'b0) begin
      errors++; $display("FAIL R10: dq_oe=%0b expected 0", dq_oe);
    end
    out_en_n = 0; #1; chk();
    @(negedge clk); chk();
    idle(2); pipe_mode = 1;

    tag = "R11";
    rd(8'h70, 0); sleep_req = 1; tick();
    addr = 8'h71; din = '0; ctl_stb_n = 0; wr_all_n = 0; tick(); tick(); quiet();
    sleep_req = 0; idle(4); rd(8'h71, 0); idle(2);

    tag = "R12";
    sleep_req = 1; tick(); sleep_req = 0;
    wr(8'h72, '0, 0, 1, '1); wr(8'h73, '0, 0, 1, '1); wr(8'h74, '0, 0, 1, '1);
    rd(8'h72, 0); rd(8'h73, 0); rd(8'h74, 0); idle(2);

    tag = "random R4 R6";
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom);
      if (c % 400 == 0) begin pipe_mode = $urandom % 2; lin_order_n = $urandom % 2; end
      cs0_n        = ($urandom % 10) == 0;
      cs1          = ($urandom % 12) != 0;
      cs2_n        = ($urandom % 15) == 0;
      host_stb_n   = ($urandom % 6) != 0;
      ctl_stb_n    = ($urandom % 4) != 0;
      burst_step_n = ($urandom % 3) == 0;
      wr_all_n     = ($urandom % 5) != 0;
      wr_byte_n    = ($urandom % 3) != 0;
      byte_sel_n   = NB'($urandom);
      out_en_n     = ($urandom % 16) == 0;
      sleep_req    = ($urandom % 97) == 0;
      addr         = AW'(r);
      din          = DW'($urandom);
      tick();
    end
    sleep_req = 0; out_en_n = 0; idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule